// File: doc/BRIEF.md
# Oscillator Start-Up Reset Sequencer

The sequencer keeps the processor core in reset after a power-on or brown-out event until both the supply and the main clock can be trusted. It captures a 3-bit oscillator mode code and a power-up-wait enable while a reset request is active. It then walks a fixed chain of waits, each of which may be skipped depending on the captured configuration. The first wait counts ticks of a slow free-running reference. The second counts edges of the main clock, and only the crystal modes use it. The third counts reference ticks while the 4x PLL settles, and only the crystal-with-PLL mode uses it.

The sequencer drives the core reset, the PLL enable and an enable for the divide-by-four clock output pin. A 2-bit phase output shows how far the sequence has reached. Each wait length is a parameter, so a short bench can use small values while silicon uses counts that match the nominal 72 ms and 2 ms windows and the 1024-edge start-up count. A new request at any point restarts the chain from the first wait.

Top module: `osc_start_seq`

## Requirements
- R1: While rst_ni is low, phase_o is 0, core_rst_o is 1 and pll_en_o is 0. Phase codes are 0 = power-up wait, 1 = clock start-up count, 2 = PLL lock wait, 3 = released.
- R2: A high por_req_i returns phase_o to 0 with core_rst_o at 1 in the next cycle, whatever the current phase. Once por_req_i drops, the whole chain runs again from the start.
- R3: With the power-up wait enabled, phase 0 lasts until PWRT_TICKS cycles with ref_tick_i high have been seen. With it disabled, phase 0 ends one clock after the request drops.
- R4: Mode codes are 0 = low-power crystal, 1 = crystal, 2 = high-speed crystal, 3 = high-speed crystal with PLL, 4 = RC, 5 = RC with the clock pin used as I/O, 6 = external clock, 7 = external clock with the clock pin used as I/O. Codes 0 to 3 spend exactly OST_CYCLES clocks in phase 1. Codes 4 to 7 skip phase 1.
- R5: Only code 3 enters phase 2, which lasts LOCK_TICKS reference ticks. Reference ticks that arrive during phase 1 have no effect on its length.
- R6: In phase 3, core_rst_o is 0. Phase 3 holds, whatever ref_tick_i does, until the next request.
- R7: pll_en_o is 1 only for code 3, and only in phases 2 and 3. It is 0 during the earlier phases.
- R8: clkout_en_o is 1 for codes 4 and 6 and 0 for every other code.
- R9: The mode and power-up-wait enable are captured only while a request is active. Changes after the request drops do not affect the running sequence or the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Main oscillator clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| por_req_i | input | 1 | Power-on or brown-out reset request, level |
| ref_tick_i | input | 1 | Single-cycle pulse from the free-running reference |
| osc_mode_i | input | 3 | Oscillator mode code |
| pwrt_en_i | input | 1 | Power-up wait enable |
| core_rst_o | output | 1 | Core reset, active high |
| pll_en_o | output | 1 | PLL enable |
| clkout_en_o | output | 1 | Enable for the divide-by-four clock output |
| phase_o | output | 2 | Current sequence phase |

## Verification
The bench measures each phase length for all eight mode codes, with and without the power-up wait. A design that counted one too many or too few edges or ticks, or that entered the wrong phase for a mode, shows up as a wrong length. The reference tick is held high throughout the start-up count, so a design that counted ticks there would shorten that phase. A request in the middle of the count must restart the full chain, so a design that resumed from the old count would finish early. Mode and enable changes after the request drops must be ignored, so a design that decoded the live pins would enter a start-up count or power-up wait that should not exist, or enable the PLL.

// File: rtl/osc_seq_pkg.sv
package osc_seq_pkg;
  typedef enum logic [2:0] {
    MODE_XTAL_LP    = 3'd0,
    MODE_XTAL       = 3'd1,
    MODE_XTAL_HS    = 3'd2,
    MODE_XTAL_PLL   = 3'd3,
    MODE_RC_CLKOUT  = 3'd4,
    MODE_RC_GPIO    = 3'd5,
    MODE_EXT_CLKOUT = 3'd6,
    MODE_EXT_GPIO   = 3'd7
  } osc_mode_e;

  typedef enum logic [1:0] {
    PH_PWRUP = 2'd0,
    PH_OSC   = 2'd1,
    PH_LOCK  = 2'd2,
    PH_RUN   = 2'd3
  } phase_e;

  typedef struct packed {
    logic xtal;
    logic pll;
    logic clkout;
    logic pwrt;
  } seq_cfg_t;
endpackage

// File: rtl/osc_seq_cfg.sv
module osc_seq_cfg
  import osc_seq_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     load_i,
  input  logic [2:0] mode_i,
  input  logic     pwrt_en_i,
  output seq_cfg_t cfg_o
);
  seq_cfg_t cfg_d, cfg_q;

  always_comb begin
    cfg_d.xtal   = ~mode_i[2];
    cfg_d.pll    = (mode_i == MODE_XTAL_PLL);
    cfg_d.clkout = (mode_i == MODE_RC_CLKOUT) || (mode_i == MODE_EXT_CLKOUT);
    cfg_d.pwrt   = pwrt_en_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cfg_q <= '0;
    else if (load_i) cfg_q <= cfg_d;
  end

  assign cfg_o = cfg_q;
endmodule

// File: rtl/osc_seq_fsm.sv
module osc_seq_fsm
  import osc_seq_pkg::*;
#(
  parameter int PWRT_TICKS = 72,
  parameter int OST_CYCLES = 1024,
  parameter int LOCK_TICKS = 2
) (
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     restart_i,
  input  logic     tick_i,
  input  seq_cfg_t cfg_i,
  output phase_e   phase_o
);
  localparam int MAX_A = (PWRT_TICKS > OST_CYCLES) ? PWRT_TICKS : OST_CYCLES;
  localparam int MAX_C = (MAX_A > LOCK_TICKS) ? MAX_A : LOCK_TICKS;
  localparam int CW    = $clog2(MAX_C + 1);
  localparam logic [CW-1:0] PWRT_LAST = CW'(PWRT_TICKS - 1);
  localparam logic [CW-1:0] OST_LAST  = CW'(OST_CYCLES - 1);
  localparam logic [CW-1:0] LOCK_LAST = CW'(LOCK_TICKS - 1);

  phase_e        ph_q, ph_d;
  logic [CW-1:0] cnt_q;
  logic          cnt_inc;

  always_comb begin
    ph_d = ph_q;
    unique case (ph_q)
      PH_PWRUP: if (!cfg_i.pwrt || (tick_i && cnt_q == PWRT_LAST))
                  ph_d = cfg_i.xtal ? PH_OSC : PH_RUN;
      PH_OSC:   if (cnt_q == OST_LAST)
                  ph_d = cfg_i.pll ? PH_LOCK : PH_RUN;
      PH_LOCK:  if (tick_i && cnt_q == LOCK_LAST) ph_d = PH_RUN;
      default:  ph_d = PH_RUN;
    endcase
  end

  // start-up phase counts main-clock edges; the others count reference ticks
  assign cnt_inc = (ph_q == PH_OSC) || (tick_i && (ph_q == PH_PWRUP || ph_q == PH_LOCK));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q  <= PH_PWRUP;
      cnt_q <= '0;
    end else if (restart_i) begin
      ph_q  <= PH_PWRUP;
      cnt_q <= '0;
    end else if (ph_d != ph_q) begin
      ph_q  <= ph_d;
      cnt_q <= '0;
    end else if (cnt_inc) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign phase_o = ph_q;
endmodule

// File: rtl/osc_start_seq.sv
module osc_start_seq
  import osc_seq_pkg::*;
#(
  parameter int PWRT_TICKS = 72,
  parameter int OST_CYCLES = 1024,
  parameter int LOCK_TICKS = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       por_req_i,
  input  logic       ref_tick_i,
  input  logic [2:0] osc_mode_i,
  input  logic       pwrt_en_i,
  output logic       core_rst_o,
  output logic       pll_en_o,
  output logic       clkout_en_o,
  output logic [1:0] phase_o
);
  seq_cfg_t cfg;
  phase_e   phase;
  logic     init_q;
  logic     restart;

  // first clock after reset behaves as a request so the config gets captured
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) init_q <= 1'b1;
    else         init_q <= 1'b0;
  end

  assign restart = por_req_i | init_q;

  osc_seq_cfg u_cfg (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (restart),
    .mode_i    (osc_mode_i),
    .pwrt_en_i (pwrt_en_i),
    .cfg_o     (cfg)
  );

  osc_seq_fsm #(
    .PWRT_TICKS (PWRT_TICKS),
    .OST_CYCLES (OST_CYCLES),
    .LOCK_TICKS (LOCK_TICKS)
  ) u_fsm (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .restart_i (restart),
    .tick_i    (ref_tick_i),
    .cfg_i     (cfg),
    .phase_o   (phase)
  );

  assign core_rst_o  = (phase != PH_RUN);
  assign pll_en_o    = cfg.pll && (phase == PH_LOCK || phase == PH_RUN);
  assign clkout_en_o = cfg.clkout;
  assign phase_o     = phase;
endmodule

// File: rtl/osc_start_seq_chk.sv
module osc_start_seq_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       por_req_i,
  input logic       ref_tick_i,
  input logic [2:0] osc_mode_i,
  input logic       pwrt_en_i,
  input logic       core_rst_o,
  input logic       pll_en_o,
  input logic       clkout_en_o,
  input logic [1:0] phase_o
);
  a_r2_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    por_req_i |=> (phase_o == 2'd0) && core_rst_o);

  a_r6_hold_run: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_o == 2'd3) && !por_req_i |=> (phase_o == 2'd3) && !core_rst_o);

  a_r7_pll_late: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pll_en_o |-> phase_o[1]);

  a_r8_clkout_no_pll: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clkout_en_o |-> !pll_en_o);

  a_r4_forward_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_o != $past(phase_o)) && (phase_o != 2'd0) |-> phase_o > $past(phase_o));

  a_r5_lock_after_osc: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_o == 2'd2) && ($past(phase_o) != 2'd2) |-> $past(phase_o) == 2'd1);
endmodule

bind osc_start_seq osc_start_seq_chk u_chk (.*);

// File: tb/osc_start_seq_tb.sv
module osc_start_seq_tb;
  localparam int PWRT_TICKS = 4;
  localparam int OST_CYCLES = 16;
  localparam int LOCK_TICKS = 3;
  localparam int NV = 10;

  // mode, pwrt, has_ost, has_lock, exp_pll, exp_clkout
  typedef struct packed {
    logic [2:0] mode;
    logic       pwrt;
    logic       ost;
    logic       lock;
    logic       pll;
    logic       clko;
  } vec_t;

  localparam vec_t VECS [NV] = '{
    8'b000_1_1_0_0_0,
    8'b001_0_1_0_0_0,
    8'b010_1_1_0_0_0,
    8'b011_1_1_1_1_0,
    8'b100_0_0_0_0_1,
    8'b101_1_0_0_0_0,
    8'b110_1_0_0_0_1,
    8'b111_0_0_0_0_0,
    8'b011_0_1_1_1_0,
    8'b100_1_0_0_0_1
  };

  logic       clk_i = 1'b0;
  logic       rst_ni, por_req_i, ref_tick_i, pwrt_en_i;
  logic [2:0] osc_mode_i;
  logic       core_rst_o, pll_en_o, clkout_en_o;
  logic [1:0] phase_o;

  int checks = 0;
  int errs   = 0;

  always #4 clk_i = ~clk_i;

  osc_start_seq #(
    .PWRT_TICKS (PWRT_TICKS),
    .OST_CYCLES (OST_CYCLES),
    .LOCK_TICKS (LOCK_TICKS)
  ) u_dut (
    .clk_i, .rst_ni, .por_req_i, .ref_tick_i, .osc_mode_i, .pwrt_en_i,
    .core_rst_o, .pll_en_o, .clkout_en_o, .phase_o
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary;
    $display("== %0d vectors applied, %0d miscompares ==", checks, errs);
  endtask

  task automatic request(input logic [2:0] m, input logic p);
    por_req_i  = 1'b1;
    osc_mode_i = m;
    pwrt_en_i  = p;
    repeat (2) @(negedge clk_i);
    por_req_i = 1'b0;
  endtask

  task automatic pulse;
    ref_tick_i = 1'b1;
    @(negedge clk_i);
    ref_tick_i = 1'b0;
  endtask

  task automatic count_ticks(input logic [1:0] ph, output int n);
    n = 0;
    while (phase_o == ph && n < 100) begin
      pulse();
      n++;
    end
  endtask

  task automatic count_osc(output int n);
    n = 0;
    ref_tick_i = 1'b1;
    while (phase_o == 2'd1 && n < 1000) begin
      @(negedge clk_i);
      n++;
    end
    ref_tick_i = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    errs++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    int   n;
    vec_t v;
    rst_ni = 1'b0; por_req_i = 1'b0; ref_tick_i = 1'b0;
    osc_mode_i = 3'd0; pwrt_en_i = 1'b0;
    repeat (3) @(negedge clk_i);
    chk("R1 phase in reset", phase_o, 0);
    chk("R1 core_rst in reset", core_rst_o, 1);
    chk("R1 pll_en in reset", pll_en_o, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    for (int i = 0; i < NV; i++) begin
      v = VECS[i];
      request(v.mode, v.pwrt);
      @(negedge clk_i);
      count_ticks(2'd0, n);
      chk($sformatf("R3 power-up ticks v%0d", i), n, v.pwrt ? PWRT_TICKS : 0);
      count_osc(n);
      chk($sformatf("R4 start-up clocks v%0d", i), n, v.ost ? OST_CYCLES : 0);
      count_ticks(2'd2, n);
      chk($sformatf("R5 lock ticks v%0d", i), n, v.lock ? LOCK_TICKS : 0);
      chk($sformatf("R6 phase v%0d", i), phase_o, 3);
      chk($sformatf("R6 core_rst v%0d", i), core_rst_o, 0);
      chk($sformatf("R7 pll_en v%0d", i), pll_en_o, v.pll);
      chk($sformatf("R8 clkout_en v%0d", i), clkout_en_o, v.clko);
    end

    // R2: request in the middle of the start-up count restarts the chain
    request(3'd1, 1'b0);
    @(negedge clk_i);
    chk("R2 entered start-up", phase_o, 1);
    repeat (5) @(negedge clk_i);
    por_req_i = 1'b1;
    @(negedge clk_i);
    chk("R2 phase after request", phase_o, 0);
    chk("R2 core_rst after request", core_rst_o, 1);
    por_req_i = 1'b0;
    @(negedge clk_i);
    count_osc(n);
    chk("R2 full start-up count after restart", n, OST_CYCLES);
    chk("R2 released", phase_o, 3);

    // R7: PLL stays off before the lock phase
    request(3'd3, 1'b0);
    @(negedge clk_i);
    chk("R7 phase start-up", phase_o, 1);
    chk("R7 pll_en off in start-up", pll_en_o, 0);
    count_osc(n);
    chk("R7 phase lock", phase_o, 2);
    chk("R7 pll_en on in lock", pll_en_o, 1);
    chk("R5 core_rst held in lock", core_rst_o, 1);
    count_ticks(2'd2, n);

    // R9: config changes after the request drops are ignored
    request(3'd6, 1'b0);
    osc_mode_i = 3'd3;
    pwrt_en_i  = 1'b1;
    @(negedge clk_i);
    chk("R9 no start-up or wait from live pins", phase_o, 3);
    chk("R9 clkout_en from captured code", clkout_en_o, 1);
    chk("R9 pll_en from captured code", pll_en_o, 0);

    // R6: released state ignores reference ticks
    for (int k = 0; k < 5; k++) pulse();
    repeat (10) @(negedge clk_i);
    chk("R6 phase held", phase_o, 3);
    chk("R6 core_rst held low", core_rst_o, 0);

    summary();
    $finish;
  end
endmodule